// File: doc/BRIEF.md
# Requestor Port with Refuse-and-Retry Flow Control

This block sits between one requestor and a cache core. It forwards requests to the core and returns responses to the requestor. Flow control in both directions works by refusing and later retrying, not by holding a ready signal. Every request offered in a cycle gets an answer in that same cycle, either accepted or refused. Once a request has been refused, the port owes the requestor a retry. The port pays that debt with a one-cycle request-retry pulse, but only when it has no response waiting.

When the requestor refuses a response, the port parks that response in a single-entry buffer. The parked response is presented again only when the requestor pulses response-retry, and the resend may itself be refused. Any retry pulse, and any "core is free" kick from the cache core, makes the port check whether it can now pay an owed request-retry.

Two sticky error flags report protocol misuse:
- a new core response that arrives while one is already parked;
- a response-retry pulse that arrives when nothing is parked.

Top module: `retry_port`

## Requirements
- R1: While a response is parked or a request-retry is owed, an offered request is refused (`reqAccept` low) and is not forwarded (`coreReqValid` low), and the refusal leaves a retry owed.
- R2: When nothing blocks, a request is forwarded in the same cycle. If the core refuses it, the requestor is refused in that cycle and a retry becomes owed.
- R3: A core response with nothing parked is presented on `rspValid`/`rspPayload` in the same cycle. If `rspAccept` is low, the response is parked and is not presented again until a response-retry arrives.
- R4: A core response that arrives while another is parked is dropped and not presented, the parked payload is kept unchanged, and `errOverrun` goes high and stays high until reset.
- R5: A `rspRetry` pulse while a response is parked presents the parked payload in that same cycle. If it is accepted the buffer empties; if it is refused, the response stays parked.
- R6: When a response-retry is handled or `coreFreeKick` is high, and a retry is owed and nothing remains parked after that edge, `reqRetry` is high for exactly the next cycle and the owed flag is cleared.
- R7: `reqRetry` never pulses while a response is parked; an owed retry stays owed until such a check can pay it.
- R8: A `rspRetry` pulse with nothing parked has no effect on responses or on request acceptance, and sets the sticky `errSpuriousRetry`.
- R9: Reset empties the park buffer, clears the owed flag, both error flags and `reqRetry`.
- R10: An accepted request reaches `coreReqPayload` unchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requestor offers a request |
| reqPayload | input | REQ_W | Request contents |
| reqAccept | output | 1 | Request taken this cycle (low while reqValid = refused) |
| reqRetry | output | 1 | One-cycle pulse: requestor may offer again |
| rspValid | output | 1 | Response presented to requestor |
| rspPayload | output | RSP_W | Response contents |
| rspAccept | input | 1 | Requestor takes the presented response |
| rspRetry | input | 1 | Requestor pulse: ready for the refused response |
| coreReqValid | output | 1 | Request forwarded to the cache core |
| coreReqPayload | output | REQ_W | Forwarded request contents |
| coreReqAccept | input | 1 | Core takes the forwarded request |
| coreRspValid | input | 1 | Core delivers a response |
| coreRspPayload | input | RSP_W | Core response contents |
| coreFreeKick | input | 1 | Core asks the port to pay an owed retry |
| errOverrun | output | 1 | Sticky: response arrived while one was parked |
| errSpuriousRetry | output | 1 | Sticky: response-retry with nothing parked |

## Verification
The bench builds the port with 8-bit request and response payloads. At that width each response can carry its own marker value. This makes it visible which payload is on `rspPayload` after an overrun: the parked one must appear, never the dropped one. With such narrow payloads, the cycle-by-cycle vector table can cover every combination that matters:
- park and then retry, with the resend accepted and with it refused again;
- a core refusal and a kick falling in the same cycle;
- an owed retry that a parked response holds back.

// File: rtl/rtp_pkg.sv
package rtp_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic parkLoad;   // capture the core response into the park buffer
    logic selParked;  // present the parked payload instead of the core one
  } dpStrobeT;

endpackage

// File: rtl/rtp_datapath.sv
module rtp_datapath
  import rtp_pkg::*;
#(
  parameter int REQ_W = 32,
  parameter int RSP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobeT         strobe,
  input  logic [REQ_W-1:0] reqPayload,
  input  logic [RSP_W-1:0] coreRspPayload,
  output logic [REQ_W-1:0] coreReqPayload,
  output logic [RSP_W-1:0] rspPayload
);

  logic [RSP_W-1:0] parkBuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parkBuf <= '0;
    end else if (strobe.parkLoad) begin
      parkBuf <= coreRspPayload;
    end
  end

  // Requests pass through untouched.
  assign coreReqPayload = reqPayload;
  assign rspPayload     = strobe.selParked ? parkBuf : coreRspPayload;

endmodule

// File: rtl/rtp_ctrl.sv
module rtp_ctrl
  import rtp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     coreReqAccept,
  input  logic     coreRspValid,
  input  logic     rspAccept,
  input  logic     rspRetry,
  input  logic     coreFreeKick,
  output logic     reqAccept,
  output logic     coreReqValid,
  output logic     rspValid,
  output logic     reqRetry,
  output logic     errOverrun,
  output logic     errSpuriousRetry,
  output dpStrobeT strobe
);

  logic parked, owed, retryQ, ovQ, spQ;
  logic resendNow, freshRsp, refuse, parkedNext, owedSet, issue;

  always_comb begin
    resendNow    = rspRetry & parked;
    freshRsp     = coreRspValid & ~parked;
    rspValid     = resendNow | freshRsp;
    coreReqValid = reqValid & ~(parked | owed);
    reqAccept    = coreReqValid & coreReqAccept;
    refuse       = reqValid & ~reqAccept;

    parkedNext = parked;
    if (resendNow) begin
      parkedNext = ~rspAccept;
    end else if (freshRsp && !rspAccept) begin
      parkedNext = 1'b1;
    end

    owedSet = owed | refuse;
    issue   = (resendNow | coreFreeKick) & owedSet & ~parkedNext;

    strobe.parkLoad  = freshRsp & ~rspAccept;
    strobe.selParked = resendNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked <= 1'b0;
      owed   <= 1'b0;
      retryQ <= 1'b0;
      ovQ    <= 1'b0;
      spQ    <= 1'b0;
    end else begin
      parked <= parkedNext;
      owed   <= issue ? 1'b0 : owedSet;
      retryQ <= issue;
      if (coreRspValid && parked) ovQ <= 1'b1;
      if (rspRetry && !parked)    spQ <= 1'b1;
    end
  end

  assign reqRetry         = retryQ;
  assign errOverrun       = ovQ;
  assign errSpuriousRetry = spQ;

  assert_blocked_refuses_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (parked || owed) && reqValid |-> !reqAccept);
  assert_refused_rsp_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && !rspAccept |=> parked);
  assert_parked_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    parked && !rspRetry |=> parked);
  assert_retry_clears_owed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reqRetry |-> !owed);
  assert_retry_only_unparked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reqRetry |-> !parked);
  assert_spurious_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    errSpuriousRetry |=> errSpuriousRetry);
  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    errOverrun |=> errOverrun);

endmodule

// File: rtl/retry_port.sv
module retry_port
  import rtp_pkg::*;
#(
  parameter int REQ_W = 32,
  parameter int RSP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [REQ_W-1:0] reqPayload,
  output logic             reqAccept,
  output logic             reqRetry,
  output logic             rspValid,
  output logic [RSP_W-1:0] rspPayload,
  input  logic             rspAccept,
  input  logic             rspRetry,
  output logic             coreReqValid,
  output logic [REQ_W-1:0] coreReqPayload,
  input  logic             coreReqAccept,
  input  logic             coreRspValid,
  input  logic [RSP_W-1:0] coreRspPayload,
  input  logic             coreFreeKick,
  output logic             errOverrun,
  output logic             errSpuriousRetry
);

  dpStrobeT strobe;

  rtp_ctrl u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .reqValid         (reqValid),
    .coreReqAccept    (coreReqAccept),
    .coreRspValid     (coreRspValid),
    .rspAccept        (rspAccept),
    .rspRetry         (rspRetry),
    .coreFreeKick     (coreFreeKick),
    .reqAccept        (reqAccept),
    .coreReqValid     (coreReqValid),
    .rspValid         (rspValid),
    .reqRetry         (reqRetry),
    .errOverrun       (errOverrun),
    .errSpuriousRetry (errSpuriousRetry),
    .strobe           (strobe)
  );

  rtp_datapath #(.REQ_W(REQ_W), .RSP_W(RSP_W)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .reqPayload     (reqPayload),
    .coreRspPayload (coreRspPayload),
    .coreReqPayload (coreReqPayload),
    .rspPayload     (rspPayload)
  );

endmodule

// File: tb/retry_port_test.sv
module retry_port_test;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, rspAccept = 1'b0, rspRetry = 1'b0;
  logic coreReqAccept = 1'b0, coreRspValid = 1'b0, coreFreeKick = 1'b0;
  logic [W-1:0] reqPayload = '0, coreRspPayload = '0;
  logic reqAccept, reqRetry, rspValid, coreReqValid, errOverrun, errSpuriousRetry;
  logic [W-1:0] rspPayload, coreReqPayload;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  retry_port #(.REQ_W(W), .RSP_W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqPayload(reqPayload), .reqAccept(reqAccept),
    .reqRetry(reqRetry), .rspValid(rspValid), .rspPayload(rspPayload),
    .rspAccept(rspAccept), .rspRetry(rspRetry),
    .coreReqValid(coreReqValid), .coreReqPayload(coreReqPayload),
    .coreReqAccept(coreReqAccept), .coreRspValid(coreRspValid),
    .coreRspPayload(coreRspPayload), .coreFreeKick(coreFreeKick),
    .errOverrun(errOverrun), .errSpuriousRetry(errSpuriousRetry)
  );

  typedef struct packed {
    logic         rv;
    logic [W-1:0] rp;
    logic         cacc;
    logic         crv;
    logic [W-1:0] crp;
    logic         racc;
    logic         rret;
    logic         kick;
    logic         eAcc;
    logic         eCv;
    logic         eRv;
    logic [W-1:0] eRp;
    logic         eRr;
    logic         eEo;
    logic         eEs;
  } vecT;

  localparam int NV = 23;
  // Fields: rv rp cacc crv crp racc rret kick | eAcc eCv eRv eRp eRr eEo eEs
  localparam vecT VEC [NV] = '{
    '{0,8'h00,0,0,8'h00,0,0,0, 0,0,0,8'h00,0,0,0}, // 0 idle
    '{1,8'h11,1,0,8'h00,0,0,0, 1,1,0,8'h00,0,0,0}, // 1 R10 forward+accept
    '{0,8'h00,0,1,8'hA1,1,0,0, 0,0,1,8'hA1,0,0,0}, // 2 R3 fresh response taken
    '{1,8'h22,0,0,8'h00,0,0,0, 0,1,0,8'h00,0,0,0}, // 3 R2 core refuses
    '{1,8'h33,1,0,8'h00,0,0,0, 0,0,0,8'h00,0,0,0}, // 4 R1 owed blocks
    '{0,8'h00,0,0,8'h00,0,0,1, 0,0,0,8'h00,0,0,0}, // 5 R6 kick
    '{0,8'h00,0,0,8'h00,0,0,0, 0,0,0,8'h00,1,0,0}, // 6 R6 retry pulse
    '{1,8'h44,1,0,8'h00,0,0,0, 1,1,0,8'h00,0,0,0}, // 7 owed cleared
    '{0,8'h00,0,1,8'hB2,0,0,0, 0,0,1,8'hB2,0,0,0}, // 8 R3 refused -> park
    '{0,8'h00,0,0,8'h00,0,0,0, 0,0,0,8'h00,0,0,0}, // 9 R3 not re-presented
    '{1,8'h55,1,0,8'h00,0,0,0, 0,0,0,8'h00,0,0,0}, // 10 R1 parked blocks
    '{0,8'h00,0,0,8'h00,0,0,1, 0,0,0,8'h00,0,0,0}, // 11 R7 kick while parked
    '{0,8'h00,0,0,8'h00,0,0,0, 0,0,0,8'h00,0,0,0}, // 12 R7 no pulse
    '{0,8'h00,0,1,8'hC3,1,0,0, 0,0,0,8'h00,0,0,0}, // 13 R4 overrun dropped
    '{0,8'h00,0,0,8'h00,0,1,0, 0,0,1,8'hB2,0,1,0}, // 14 R5 resend refused
    '{0,8'h00,0,0,8'h00,0,0,0, 0,0,0,8'h00,0,1,0}, // 15 R7 still parked
    '{0,8'h00,0,0,8'h00,1,1,0, 0,0,1,8'hB2,0,1,0}, // 16 R5 resend taken
    '{0,8'h00,0,0,8'h00,0,0,0, 0,0,0,8'h00,1,1,0}, // 17 R6 pulse after retry
    '{0,8'h00,0,0,8'h00,0,1,0, 0,0,0,8'h00,0,1,0}, // 18 R8 spurious retry
    '{0,8'h00,0,0,8'h00,0,0,0, 0,0,0,8'h00,0,1,1}, // 19 R8 sticky flag
    '{1,8'h66,1,0,8'h00,0,0,0, 1,1,0,8'h00,0,1,1}, // 20 R8 no effect on accept
    '{1,8'h77,0,1,8'hD4,1,0,1, 0,1,1,8'hD4,0,1,1}, // 21 R2/R6 refuse+kick same cycle
    '{0,8'h00,0,0,8'h00,0,0,0, 0,0,0,8'h00,1,1,1}  // 22 R6 pulse
  };

  task automatic check(input string tag, input int step, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s step %0d: actual=%h expected=%h", tag, step, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqPayload = '0; coreReqAccept = 0; coreRspValid = 0;
    coreRspPayload = '0; rspAccept = 0; rspRetry = 0; coreFreeKick = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R9: reset state
    #5;
    check("R9 reqRetry", -1, 16'(reqRetry), 16'd0);
    check("R9 errOverrun", -1, 16'(errOverrun), 16'd0);
    check("R9 errSpuriousRetry", -1, 16'(errSpuriousRetry), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reqValid       = VEC[i].rv;
      reqPayload     = VEC[i].rp;
      coreReqAccept  = VEC[i].cacc;
      coreRspValid   = VEC[i].crv;
      coreRspPayload = VEC[i].crp;
      rspAccept      = VEC[i].racc;
      rspRetry       = VEC[i].rret;
      coreFreeKick   = VEC[i].kick;
      #5;
      check("R1/R2/R10 reqAccept", i, 16'(reqAccept), 16'(VEC[i].eAcc));
      check("R1/R2 coreReqValid", i, 16'(coreReqValid), 16'(VEC[i].eCv));
      if (VEC[i].eCv)
        check("R10 coreReqPayload", i, 16'(coreReqPayload), 16'(VEC[i].rp));
      check("R3/R4/R5 rspValid", i, 16'(rspValid), 16'(VEC[i].eRv));
      if (VEC[i].eRv)
        check("R3/R4/R5 rspPayload", i, 16'(rspPayload), 16'(VEC[i].eRp));
      check("R6/R7 reqRetry", i, 16'(reqRetry), 16'(VEC[i].eRr));
      check("R4 errOverrun", i, 16'(errOverrun), 16'(VEC[i].eEo));
      check("R8 errSpuriousRetry", i, 16'(errSpuriousRetry), 16'(VEC[i].eEs));
    end

    // R9: reset from a parked and owed state
    @(negedge clk);
    idle();
    coreRspValid = 1; coreRspPayload = 8'hE5; rspAccept = 0;  // park
    reqValid = 1; coreReqAccept = 0;                          // owe a retry
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R9 errOverrun after reset", 100, 16'(errOverrun), 16'd0);
    check("R9 errSpuriousRetry after reset", 100, 16'(errSpuriousRetry), 16'd0);
    check("R9 reqRetry after reset", 100, 16'(reqRetry), 16'd0);
    @(negedge clk);
    reqValid = 1; reqPayload = 8'h99; coreReqAccept = 1;
    #5;
    check("R9 owed cleared: request accepted", 101, 16'(reqAccept), 16'd1);
    @(negedge clk);
    idle();
    rspRetry = 1;  // nothing parked any more
    #5;
    check("R9 park buffer empty: no resend", 102, 16'(rspValid), 16'd0);
    @(negedge clk);
    idle();
    #5;
    check("R8 spurious after reset flagged", 103, 16'(errSpuriousRetry), 16'd1);

    finishRun();
  end

endmodule